// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This block is the sequencer of a nonvolatile SRAM. It copies the volatile array into its nonvolatile shadow (a store) and copies the shadow back into the array (a recall). It drives the cell array through four phase strobes: erase and program for a store, and clear and transfer for a recall. While an operation runs, it closes the array to outside accesses. Each phase lasts a parameterised number of clock cycles.

Work can start in four ways:
- **Supply loss.** A supply-good input falls. This causes a store, followed later by a recall.
- **Shared request line.** An active-low line falls. Other devices can also drive this line, and the block pulls it low itself while it stores.
- **Software store.** A one-cycle command.
- **Software recall.** A one-cycle command.

A write flag records whether the array has been written since the last store or recall. The flag only affects supply-loss and line-requested stores. A software store runs whether or not the flag is set.

The controller has nine states:
- `ST_IDLE`: open for reads and writes.
- `ST_HWWAIT`: the grace window after the line falls. Reads are still served.
- `ST_PFCHK`: a one-cycle check that the line really went low.
- `ST_ERASE`, then `ST_PROG`: the two store phases.
- `ST_RELWAIT`: the line is released, and the block waits until it reads high.
- `ST_CLEAR`, then `ST_XFER`: the two recall phases.
- `ST_DOWN`: the supply is absent.

Transitions:
- **From `ST_IDLE`, checked in this priority order:**
  1. A latched supply loss goes to `ST_PFCHK` if the flag is set, otherwise to `ST_DOWN`.
  2. A falling edge on the line goes to `ST_HWWAIT` if the flag is set, otherwise the block stays in `ST_IDLE`.
  3. A software store goes to `ST_ERASE`.
  4. A software recall goes to `ST_CLEAR`.
- **Timed phases:** `ST_HWWAIT` → `ST_ERASE` → `ST_PROG` → `ST_RELWAIT`, and `ST_CLEAR` → `ST_XFER` → `ST_IDLE`.
- **From `ST_PFCHK`:** to `ST_ERASE` if the line is low, otherwise to `ST_DOWN` (the attempt is aborted).
- **From `ST_RELWAIT`:** once the line is high, to `ST_DOWN` if a recall is pending, otherwise to `ST_IDLE`.
- **From `ST_DOWN`:** to `ST_CLEAR` once the supply is good.

Reset enters `ST_DOWN` with a recall pending, so the block performs a power-up recall.

Top module: `nvstash_ctrl`

## Requirements
- R1: Reset places the block in the powered-down state with a recall pending. No strobe and no line pull are active, and no access is granted. Once `pwr_ok` is high, a recall runs.
- R2: A granted write sets the write flag. A supply-loss or line-requested store starts only while the flag is set. Otherwise the line fall is let pass, or the block powers down without storing.
- R3: A software store runs even when the write flag is clear.
- R4: After a falling edge of `line_n` with the flag set, reads stay granted for `DELAY_CYC` cycles before erase begins. Writes are never granted while `line_n` is low.
- R5: A store asserts `nv_erase` for `ERASE_CYC` cycles, then `nv_program` for `PROG_CYC` cycles. `line_pull` is asserted throughout both phases.
- R6: After a store, no access is granted until `line_n` is sensed high.
- R7: A recall asserts `arr_clear` for `CLEAR_CYC` cycles, then `nv_transfer` for `XFER_CYC` cycles, with no erase or program. The write flag is clear afterwards, as it also is after a store.
- R8: A fall of `pwr_ok` latches a recall. The block then grants nothing until `pwr_ok` is high again, and then performs the recall.
- R9: A supply-loss store whose line pull does not bring `line_n` low is abandoned, with no erase.
- R10: Software and line requests that arrive during an operation are ignored. A supply loss during an operation is held and acted on afterwards.
- R11: At most one of the four phase strobes is high in any cycle.

Strobe vector used by the checks: {`arr_clear`, `nv_transfer`, `nv_erase`, `nv_program`}. The encodings are clear = 4'b1000, transfer = 4'b0100, erase = 4'b0010, program = 4'b0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply above the switch threshold |
| line_n | input | 1 | Sensed level of the shared active-low store line |
| line_pull | output | 1 | Pull the shared line low (open-drain control) |
| sw_store | input | 1 | One-cycle software store command |
| sw_recall | input | 1 | One-cycle software recall command |
| acc_rd | input | 1 | Array read request |
| acc_wr | input | 1 | Array write request |
| rd_ok | output | 1 | Read granted this cycle |
| wr_ok | output | 1 | Write granted this cycle |
| nv_erase | output | 1 | Erase-shadow phase strobe |
| nv_program | output | 1 | Program-shadow phase strobe |
| arr_clear | output | 1 | Clear-array phase strobe |
| nv_transfer | output | 1 | Shadow-to-array transfer strobe |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `line_n` follows `line_pull` in the same cycle unless something external holds the line high. The bench models the line as a wired-AND of the block's pull and a second device's pull. An optional strong high driver overrides it, which is how R9 is reached. The assertions also assume that software commands last one cycle. The bench drives every input on the falling clock edge, pulses commands for exactly one cycle, and lets each operation drain before it starts the next one. The exceptions are the deliberate mid-operation requests used for R10.

// File: rtl/nvstash_pkg.sv
package nvstash_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HWWAIT,
        ST_PFCHK,
        ST_ERASE,
        ST_PROG,
        ST_RELWAIT,
        ST_CLEAR,
        ST_XFER,
        ST_DOWN
    } nv_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvstash_timer.sv
module nvstash_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nvstash_gate.sv
module nvstash_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_rd,
    input  logic acc_wr,
    input  logic rd_open,
    input  logic wr_open,
    input  logic line_n,
    input  logic pwr_ok,
    input  logic clr_dirty,
    output logic rd_ok,
    output logic wr_ok,
    output logic dirty
);
    assign rd_ok = acc_rd & rd_open;
    assign wr_ok = acc_wr & wr_open & line_n & pwr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dirty <= 1'b0;
        else if (wr_ok)
            dirty <= 1'b1;
        else if (clr_dirty)
            dirty <= 1'b0;
    end

    // R2
    dirty_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty) |-> $past(wr_ok));

    // R7
    dirty_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dirty && !wr_ok) |=> !dirty);
endmodule

// File: rtl/nvstash_seq.sv
module nvstash_seq
    import nvstash_pkg::*;
#(
    parameter int DELAY_CYC = 8,
    parameter int ERASE_CYC = 6,
    parameter int PROG_CYC  = 10,
    parameter int CLEAR_CYC = 4,
    parameter int XFER_CYC  = 5,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          line_n,
    input  logic          sw_store,
    input  logic          sw_recall,
    input  logic          dirty,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          clr_dirty,
    output logic          rd_open,
    output logic          wr_open,
    output logic          line_pull,
    output logic          nv_erase,
    output logic          nv_program,
    output logic          arr_clear,
    output logic          nv_transfer
);
    nv_state_t state, state_nx;
    logic line_q, pwr_q, pf_pend, rc_pend;
    logic hw_fall, pwr_fall;

    assign hw_fall  = line_q & ~line_n;
    assign pwr_fall = pwr_q & ~pwr_ok;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (pf_pend)
                    state_nx = dirty ? ST_PFCHK : ST_DOWN;
                else if (hw_fall && dirty)
                    state_nx = ST_HWWAIT;
                else if (hw_fall)
                    state_nx = ST_IDLE;
                else if (sw_store)
                    state_nx = ST_ERASE;
                else if (sw_recall)
                    state_nx = ST_CLEAR;
            end
            ST_HWWAIT:  if (tmr_zero) state_nx = ST_ERASE;
            ST_PFCHK:   state_nx = line_n ? ST_DOWN : ST_ERASE;
            ST_ERASE:   if (tmr_zero) state_nx = ST_PROG;
            ST_PROG:    if (tmr_zero) state_nx = ST_RELWAIT;
            ST_RELWAIT: if (line_n) state_nx = rc_pend ? ST_DOWN : ST_IDLE;
            ST_CLEAR:   if (tmr_zero) state_nx = ST_XFER;
            ST_XFER:    if (tmr_zero) state_nx = ST_IDLE;
            ST_DOWN:    if (pwr_ok) state_nx = ST_CLEAR;
            default:    state_nx = ST_DOWN;
        endcase
    end

    // state register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DOWN;
            line_q  <= 1'b1;
            pwr_q   <= 1'b0;
            pf_pend <= 1'b0;
            rc_pend <= 1'b1;
        end else begin
            state  <= state_nx;
            line_q <= line_n;
            pwr_q  <= pwr_ok;
            if (pwr_fall)
                pf_pend <= 1'b1;
            else if (state_nx == ST_DOWN || state_nx == ST_PFCHK)
                pf_pend <= 1'b0;
            if (pwr_fall)
                rc_pend <= 1'b1;
            else if (state_nx == ST_CLEAR)
                rc_pend <= 1'b0;
        end
    end

    // timer load on every state change into a timed state
    always_comb begin
        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_HWWAIT: tmr_val = CW'(DELAY_CYC - 1);
            ST_ERASE:  tmr_val = CW'(ERASE_CYC - 1);
            ST_PROG:   tmr_val = CW'(PROG_CYC - 1);
            ST_CLEAR:  tmr_val = CW'(CLEAR_CYC - 1);
            ST_XFER:   tmr_val = CW'(XFER_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    // outputs from state
    always_comb begin
        rd_open     = 1'b0;
        wr_open     = 1'b0;
        line_pull   = 1'b0;
        nv_erase    = 1'b0;
        nv_program  = 1'b0;
        arr_clear   = 1'b0;
        nv_transfer = 1'b0;
        clr_dirty   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rd_open = 1'b1;
                wr_open = 1'b1;
            end
            ST_HWWAIT: rd_open = 1'b1;
            ST_PFCHK:  line_pull = 1'b1;
            ST_ERASE: begin
                line_pull = 1'b1;
                nv_erase  = 1'b1;
            end
            ST_PROG: begin
                line_pull  = 1'b1;
                nv_program = 1'b1;
                clr_dirty  = tmr_zero;
            end
            ST_CLEAR: arr_clear = 1'b1;
            ST_XFER: begin
                nv_transfer = 1'b1;
                clr_dirty   = tmr_zero;
            end
            default: ;
        endcase
    end

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_clear, nv_transfer, nv_erase, nv_program}));

    // R5
    erase_before_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_program) |-> $past(nv_erase));

    // R7
    clear_before_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_transfer) |-> $past(arr_clear));

    // R3
    sw_store_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sw_store && !pf_pend && !hw_fall) |=> nv_erase);

    // R4
    hw_window_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hw_fall && dirty && !pf_pend) |=> (rd_open && !nv_erase));

    // R6
    hold_until_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELWAIT && !line_n) |=> !rd_open);

    // R9
    pf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PFCHK && line_n) |=> !nv_erase);
endmodule

// File: rtl/nvstash_ctrl.sv
module nvstash_ctrl
    import nvstash_pkg::*;
#(
    parameter int DELAY_CYC = 8,
    parameter int ERASE_CYC = 6,
    parameter int PROG_CYC  = 10,
    parameter int CLEAR_CYC = 4,
    parameter int XFER_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic line_n,
    output logic line_pull,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic acc_rd,
    input  logic acc_wr,
    output logic rd_ok,
    output logic wr_ok,
    output logic nv_erase,
    output logic nv_program,
    output logic arr_clear,
    output logic nv_transfer
);
    localparam int MAXC = imax(imax(DELAY_CYC, ERASE_CYC),
                               imax(PROG_CYC, imax(CLEAR_CYC, XFER_CYC)));
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic          tmr_load, tmr_zero, clr_dirty, dirty, rd_open, wr_open;
    logic [CW-1:0] tmr_val;

    nvstash_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    nvstash_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .rd_open  (rd_open),
        .wr_open  (wr_open),
        .line_n   (line_n),
        .pwr_ok   (pwr_ok),
        .clr_dirty(clr_dirty),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .dirty    (dirty)
    );

    nvstash_seq #(
        .DELAY_CYC(DELAY_CYC),
        .ERASE_CYC(ERASE_CYC),
        .PROG_CYC (PROG_CYC),
        .CLEAR_CYC(CLEAR_CYC),
        .XFER_CYC (XFER_CYC),
        .CW       (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .line_n     (line_n),
        .sw_store   (sw_store),
        .sw_recall  (sw_recall),
        .dirty      (dirty),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .clr_dirty  (clr_dirty),
        .rd_open    (rd_open),
        .wr_open    (wr_open),
        .line_pull  (line_pull),
        .nv_erase   (nv_erase),
        .nv_program (nv_program),
        .arr_clear  (arr_clear),
        .nv_transfer(nv_transfer)
    );
endmodule

// File: tb/nvstash_ctrl_test.sv
module nvstash_ctrl_test;
    localparam int DLY = 8, ERS = 6, PRG = 10, CLR = 4, XFR = 5;
    localparam logic [3:0] V_CLR = 4'b1000, V_XFR = 4'b0100,
                           V_ERS = 4'b0010, V_PRG = 4'b0001;

    logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, acc_rd = 1'b0, acc_wr = 1'b0;
    logic ext_pull = 1'b0, ext_hold = 1'b0;
    logic line_n, line_pull, rd_ok, wr_ok, nv_erase, nv_program, arr_clear, nv_transfer;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    assign line_n = ext_hold ? 1'b1 : ~(line_pull | ext_pull);

    nvstash_ctrl #(.DELAY_CYC(DLY), .ERASE_CYC(ERS), .PROG_CYC(PRG),
                   .CLEAR_CYC(CLR), .XFER_CYC(XFR)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .line_n(line_n),
        .line_pull(line_pull), .sw_store(sw_store), .sw_recall(sw_recall),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .nv_erase(nv_erase), .nv_program(nv_program),
        .arr_clear(arr_clear), .nv_transfer(nv_transfer)
    );

    // scoreboard: expected {tag, phase vector, length}
    typedef struct { string tag; logic [3:0] vec; int len; } exp_t;
    exp_t exp_q[$];

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input string tag, input logic [3:0] v, input int len);
        exp_t e;
        e.tag = tag; e.vec = v; e.len = len;
        exp_q.push_back(e);
    endtask

    task automatic push_store(input string tag);
        push(tag, V_ERS, ERS);
        push(tag, V_PRG, PRG);
    endtask

    task automatic push_recall(input string tag);
        push(tag, V_CLR, CLR);
        push(tag, V_XFR, XFR);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: measures each strobe run and compares it with the queue head
    logic [3:0] cur = 4'b0;
    int         run = 0;
    always @(negedge clk) begin
        logic [3:0] v;
        v = {arr_clear, nv_transfer, nv_erase, nv_program};
        if (rst_n && v != cur) begin
            if (cur != 4'b0) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected phase", int'(cur), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({e.tag, " phase code"}, int'(cur), int'(e.vec));
                    chk({e.tag, " phase length"}, run, e.len);
                end
            end
            cur = v;
            run = 1;
        end else if (rst_n && v != 4'b0) begin
            run++;
        end
    end

    task automatic do_write(input string tag);
        acc_wr = 1'b1;
        #1 chk({tag, " write granted"}, int'(wr_ok), 1);
        tick(1);
        acc_wr = 1'b0;
    endtask

    task automatic pulse_store();
        sw_store = 1'b1; tick(1); sw_store = 1'b0;
    endtask

    task automatic pulse_recall();
        sw_recall = 1'b1; tick(1); sw_recall = 1'b0;
    endtask

    task automatic drained(input string tag);
        chk({tag, " queue drained"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        acc_rd = 1'b1; acc_wr = 1'b1;
        tick(2);
        chk("R1 strobes in reset", int'({arr_clear, nv_transfer, nv_erase, nv_program}), 0);
        chk("R1 no pull in reset", int'(line_pull), 0);
        chk("R1 no read grant in reset", int'(rd_ok), 0);
        chk("R1 no write grant in reset", int'(wr_ok), 0);
        acc_rd = 1'b0; acc_wr = 1'b0;
        push_recall("R1 power-up recall");
        rst_n = 1'b1;
        tick(15);
        drained("R1");
        acc_rd = 1'b1;
        #1 chk("R1 reads open after power-up", int'(rd_ok), 1);
        acc_rd = 1'b0;

        // R2 / R4: line falls while clean -> no store, writes blocked
        ext_pull = 1'b1;
        tick(3);
        acc_wr = 1'b1; acc_rd = 1'b1;
        #1 chk("R4 write blocked while line low", int'(wr_ok), 0);
        chk("R2 reads still served when clean", int'(rd_ok), 1);
        acc_wr = 1'b0; acc_rd = 1'b0;
        tick(25);
        ext_pull = 1'b0;
        tick(2);
        drained("R2 clean line request");

        // R4 / R5 / R6: dirty line-requested store
        do_write("R2");
        push_store("R5 line store");
        ext_pull = 1'b1;
        tick(3);
        acc_rd = 1'b1; acc_wr = 1'b1;
        #1 chk("R4 read in grace window", int'(rd_ok), 1);
        chk("R4 write blocked in grace window", int'(wr_ok), 0);
        acc_wr = 1'b0;
        tick(8);
        chk("R5 erase active", int'(nv_erase), 1);
        chk("R5 pull during erase", int'(line_pull), 1);
        tick(8);
        chk("R5 pull during program", int'(line_pull), 1);
        tick(11);
        chk("R6 no read while line held", int'(rd_ok), 0);
        tick(5);
        chk("R6 still no read while line held", int'(rd_ok), 0);
        ext_pull = 1'b0;
        tick(1);
        #1 chk("R6 reads reopen after line high", int'(rd_ok), 1);
        acc_rd = 1'b0;
        drained("R5");

        // R7: flag clear after store -> second line request stores nothing
        ext_pull = 1'b1; tick(30); ext_pull = 1'b0; tick(2);
        drained("R7 flag cleared by store");

        // R3 / R10: software store while clean; mid-operation commands ignored
        push_store("R3 software store");
        pulse_store();
        tick(3);
        acc_rd = 1'b1;
        #1 chk("R10 no read during store", int'(rd_ok), 0);
        acc_rd = 1'b0;
        pulse_recall();
        pulse_store();
        ext_pull = 1'b1; tick(2); ext_pull = 1'b0;
        tick(25);
        drained("R3");

        // R7: software recall clears the flag
        do_write("R7");
        push_recall("R7 software recall");
        pulse_recall();
        tick(15);
        drained("R7");
        ext_pull = 1'b1; tick(30); ext_pull = 1'b0; tick(2);
        drained("R7 flag cleared by recall");

        // R8: supply loss while clean -> down, then recall
        pwr_ok = 1'b0;
        tick(6);
        acc_rd = 1'b1; acc_wr = 1'b1;
        #1 chk("R8 no read while down", int'(rd_ok), 0);
        chk("R8 no write while down", int'(wr_ok), 0);
        acc_rd = 1'b0; acc_wr = 1'b0;
        push_recall("R8 recall on supply return");
        pwr_ok = 1'b1;
        tick(15);
        drained("R8");

        // R9: dirty supply loss with line held high -> abort
        do_write("R9");
        ext_hold = 1'b1;
        pwr_ok = 1'b0;
        tick(20);
        chk("R9 no erase after abort", int'(nv_erase), 0);
        drained("R9 abort");
        ext_hold = 1'b0;
        push_recall("R9 recall after abort");
        pwr_ok = 1'b1;
        tick(15);
        drained("R9");

        // R2 / R8: dirty supply loss -> store then recall
        do_write("R8");
        push_store("R2 supply-loss store");
        pwr_ok = 1'b0;
        tick(30);
        acc_rd = 1'b1;
        #1 chk("R8 no read after store while down", int'(rd_ok), 0);
        acc_rd = 1'b0;
        push_recall("R8 recall after store");
        pwr_ok = 1'b1;
        tick(15);
        drained("R2 supply-loss");

        // R10: supply loss during recall is held for later
        push_recall("R10 software recall");
        pulse_recall();
        pwr_ok = 1'b0;
        tick(15);
        acc_rd = 1'b1;
        #1 chk("R10 held supply loss powers down", int'(rd_ok), 0);
        acc_rd = 1'b0;
        push_recall("R10 held recall");
        pwr_ok = 1'b1;
        tick(15);
        drained("R10");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule